// File: doc/BRIEF.md
# CPU program bank translator

This block turns a 16-bit CPU address into a physical program-memory address. The CPU space is split into eight windows of 8 KB. Each window holds a bank number and an 8-bit tag that names the memory behind it. The top three address bits pick the window. The physical address is the bank number times 0x2000 plus the low 13 address bits. The lookup is purely combinational and reads from registered window state, so a new CPU address gives a new result in the same cycle.

A single write port changes the window state, and a write takes effect at the next rising clock edge. Each write chooses one operation:

- one window receives one bank;
- a 16 KB pair receives two consecutive banks;
- the upper 32 KB receives four consecutive banks;
- the upper 32 KB receives four separately given banks;
- one window is retagged.

Every bank number is reduced modulo the ROM bank count, which is a power-of-two parameter, so the reduction is a mask.

The block has no state machine. Its only sequential behaviour is the per-window register load, which has two transitions: hold, or load on the next edge.

Top module: `prg_bank_xlat`

## Requirements
- R1: After reset, windows 4 to 7 hold banks 0, 1, 2 and 3, each taken modulo ROM_BANKS and tagged ROM (0x00). Windows 0 to 3 hold bank 0 and are tagged RAM (0xFF).
- R2: In the same cycle, with no clock edge, phys_addr equals bank × 0x2000 plus cpu_addr[12:0], and mem_type equals the tag of window cpu_addr[15:13].
- R3: wr_en with wr_op=1 loads window wr_win with bank0 mod ROM_BANKS and tag ROM, effective from the next clock edge. The other windows are unchanged.
- R4: wr_op=2 loads window p=wr_win with (2×bank0) mod ROM_BANKS and window (p+1) mod 8 with (2×bank0+1) mod ROM_BANKS. Both windows are tagged ROM and the others are unchanged.
- R5: wr_op=3 loads windows 4+k, for k=0..3, with (4×bank0+k) mod ROM_BANKS, tagged ROM. Windows 0 to 3 are unchanged.
- R6: wr_op=4 loads windows 4+k with bankk mod ROM_BANKS, tagged ROM. Windows 0 to 3 are unchanged.
- R7: wr_op=5 sets the bank of window wr_win to 0 and its tag from wr_kind: 0→0x00 ROM, 1→0xFF RAM, 2→0x01 disk RAM, 3→0x80 mapper-handled.
- R8: With wr_en low, or with wr_op equal to 0, 6 or 7, no window changes.
- R9: Every window tag is always one of 0x00, 0xFF, 0x01 or 0x80.

Field positions: bankk is wr_banks[8k+7:8k]. ROM_BANKS defaults to 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_op | input | 3 | Write operation code |
| wr_win | input | 3 | Target window (operations 1, 2 and 5) |
| wr_banks | input | 4×BANK_W | Bank numbers 0 to 3 |
| wr_kind | input | 2 | Tag select for operation 5 |
| cpu_addr | input | 16 | CPU address |
| phys_addr | output | log2(ROM_BANKS)+13 | Physical address |
| mem_type | output | 8 | Tag of the selected window |

## Verification
The lookup results, phys_addr and mem_type, are due in the same cycle as a change of cpu_addr. The bench therefore samples them 1 ns after each address change, with no clock edge in between. A write is due at the first rising edge after it is presented. The bench drives each write on a falling edge and drops wr_en on the following falling edge. Only after that does it sweep all eight windows, at both a varying offset and the last offset of each window, against a model updated arithmetically from the requirement of each operation. Ignored writes get the same sweep, so an unintended change is visible at the ports.

// File: rtl/prg_xlat_pkg.sv
package prg_xlat_pkg;

    localparam int NWIN  = 8;
    localparam int WIN_W = 3;
    localparam int OFS_W = 13;

    localparam logic [7:0] TAG_ROM    = 8'h00;
    localparam logic [7:0] TAG_RAM    = 8'hFF;
    localparam logic [7:0] TAG_DISK   = 8'h01;
    localparam logic [7:0] TAG_MAPPER = 8'h80;

    localparam logic [2:0] OP_IDLE   = 3'd0;
    localparam logic [2:0] OP_SET8   = 3'd1;
    localparam logic [2:0] OP_SET16  = 3'd2;
    localparam logic [2:0] OP_SET32  = 3'd3;
    localparam logic [2:0] OP_SET32Q = 3'd4;
    localparam logic [2:0] OP_TAG    = 3'd5;

    function automatic logic [7:0] kind_to_tag(input logic [1:0] kind);
        case (kind)
            2'd0:    return TAG_ROM;
            2'd1:    return TAG_RAM;
            2'd2:    return TAG_DISK;
            default: return TAG_MAPPER;
        endcase
    endfunction

endpackage

// File: rtl/prg_wr_decode.sv
module prg_wr_decode
    import prg_xlat_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic                              wr_en,
    input  logic [2:0]                        wr_op,
    input  logic [WIN_W-1:0]                  wr_win,
    input  logic [4*BANK_W-1:0]               wr_banks,
    input  logic [1:0]                        wr_kind,
    output logic [NWIN-1:0]                   upd,
    output logic [NWIN-1:0][IDX_W-1:0]        nbank,
    output logic [NWIN-1:0][7:0]              ntag
);

    localparam int WIDE_W = BANK_W + 2;

    logic [WIDE_W-1:0] b_x2;
    logic [WIDE_W-1:0] b_x4;
    logic [WIN_W-1:0]  win_next;

    assign b_x2     = {1'b0, wr_banks[BANK_W-1:0], 1'b0};
    assign b_x4     = {wr_banks[BANK_W-1:0], 2'b00};
    assign win_next = wr_win + 3'd1;

    function automatic logic [IDX_W-1:0] fold(input logic [WIDE_W-1:0] v);
        return v[IDX_W-1:0];
    endfunction

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        localparam logic [WIN_W-1:0] IDX = WIN_W'(i);
        localparam logic [1:0]       SUB = 2'(i % 4);

        logic [WIDE_W-1:0] own_bank;
        assign own_bank = WIDE_W'(wr_banks[int'(SUB)*BANK_W +: BANK_W]);

        always_comb begin
            upd[i]   = 1'b0;
            nbank[i] = '0;
            ntag[i]  = TAG_ROM;
            if (wr_en) begin
                case (wr_op)
                    OP_SET8: begin
                        if (wr_win == IDX) begin
                            upd[i]   = 1'b1;
                            nbank[i] = fold(WIDE_W'(wr_banks[BANK_W-1:0]));
                        end
                    end
                    OP_SET16: begin
                        if (wr_win == IDX) begin
                            upd[i]   = 1'b1;
                            nbank[i] = fold(b_x2);
                        end else if (win_next == IDX) begin
                            upd[i]   = 1'b1;
                            nbank[i] = fold(b_x2 | WIDE_W'(1));
                        end
                    end
                    OP_SET32: begin
                        if (IDX[2]) begin
                            upd[i]   = 1'b1;
                            nbank[i] = fold(b_x4 | WIDE_W'(SUB));
                        end
                    end
                    OP_SET32Q: begin
                        if (IDX[2]) begin
                            upd[i]   = 1'b1;
                            nbank[i] = fold(own_bank);
                        end
                    end
                    OP_TAG: begin
                        if (wr_win == IDX) begin
                            upd[i]   = 1'b1;
                            nbank[i] = '0;
                            ntag[i]  = kind_to_tag(wr_kind);
                        end
                    end
                    default: begin
                        upd[i] = 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/prg_win_reg.sv
module prg_win_reg #(
    parameter int             IDX_W    = 4,
    parameter logic [IDX_W-1:0] RST_BANK = '0,
    parameter logic [7:0]     RST_TAG  = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [IDX_W-1:0] nbank,
    input  logic [7:0]       ntag,
    output logic [IDX_W-1:0] bank,
    output logic [7:0]       tag
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank <= RST_BANK;
            tag  <= RST_TAG;
        end else if (upd) begin
            bank <= nbank;
            tag  <= ntag;
        end
    end

endmodule

// File: rtl/prg_lookup.sv
module prg_lookup
    import prg_xlat_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [NWIN-1:0][IDX_W-1:0] cur_bank,
    input  logic [NWIN-1:0][7:0]       cur_tag,
    input  logic [15:0]                cpu_addr,
    output logic [IDX_W+OFS_W-1:0]     phys_addr,
    output logic [7:0]                 mem_type
);

    logic [WIN_W-1:0] sel;

    assign sel       = cpu_addr[15:13];
    assign phys_addr = {cur_bank[sel], cpu_addr[OFS_W-1:0]};
    assign mem_type  = cur_tag[sel];

endmodule

// File: rtl/prg_bank_xlat.sv
module prg_bank_xlat
    import prg_xlat_pkg::*;
#(
    parameter int ROM_BANKS = 16,
    parameter int BANK_W    = 8,
    localparam int IDX_W    = $clog2(ROM_BANKS),
    localparam int PHYS_W   = IDX_W + 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_op,
    input  logic [2:0]          wr_win,
    input  logic [4*BANK_W-1:0] wr_banks,
    input  logic [1:0]          wr_kind,
    input  logic [15:0]         cpu_addr,
    output logic [PHYS_W-1:0]   phys_addr,
    output logic [7:0]          mem_type
);

    logic [NWIN-1:0]             upd;
    logic [NWIN-1:0][IDX_W-1:0]  nxt_bank;
    logic [NWIN-1:0][7:0]        nxt_tag;
    logic [NWIN-1:0][IDX_W-1:0]  cur_bank;
    logic [NWIN-1:0][7:0]        cur_tag;

    prg_wr_decode #(
        .BANK_W (BANK_W),
        .IDX_W  (IDX_W)
    ) u_dec (
        .wr_en    (wr_en),
        .wr_op    (wr_op),
        .wr_win   (wr_win),
        .wr_banks (wr_banks),
        .wr_kind  (wr_kind),
        .upd      (upd),
        .nbank    (nxt_bank),
        .ntag     (nxt_tag)
    );

    for (genvar i = 0; i < NWIN; i++) begin : g_reg
        localparam logic [IDX_W-1:0] RB = (i >= 4) ? IDX_W'(i - 4) : '0;
        localparam logic [7:0]       RT = (i >= 4) ? TAG_ROM : TAG_RAM;

        prg_win_reg #(
            .IDX_W    (IDX_W),
            .RST_BANK (RB),
            .RST_TAG  (RT)
        ) u_win (
            .clk   (clk),
            .rst_n (rst_n),
            .upd   (upd[i]),
            .nbank (nxt_bank[i]),
            .ntag  (nxt_tag[i]),
            .bank  (cur_bank[i]),
            .tag   (cur_tag[i])
        );
    end

    prg_lookup #(
        .IDX_W (IDX_W)
    ) u_look (
        .cur_bank  (cur_bank),
        .cur_tag   (cur_tag),
        .cpu_addr  (cpu_addr),
        .phys_addr (phys_addr),
        .mem_type  (mem_type)
    );

endmodule

// File: rtl/prg_bank_xlat_chk.sv
module prg_bank_xlat_chk #(
    parameter int ROM_BANKS = 16,
    parameter int BANK_W    = 8,
    localparam int IDX_W    = $clog2(ROM_BANKS),
    localparam int PHYS_W   = IDX_W + 13
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [2:0]               wr_op,
    input logic [2:0]               wr_win,
    input logic [4*BANK_W-1:0]      wr_banks,
    input logic [15:0]              cpu_addr,
    input logic [PHYS_W-1:0]        phys_addr,
    input logic [7:0]               mem_type,
    input logic [7:0][IDX_W-1:0]    cur_bank,
    input logic [7:0][7:0]          cur_tag
);

    logic             tags_legal;
    logic [IDX_W-1:0] top_expect;
    logic [2:0]       pair_win;

    assign top_expect = IDX_W'({wr_banks[BANK_W-1:0], 2'b11});
    assign pair_win   = wr_win + 3'd1;

    always_comb begin
        tags_legal = 1'b1;
        for (int i = 0; i < 8; i++) begin
            if (!(cur_tag[i] == 8'h00 || cur_tag[i] == 8'hFF ||
                  cur_tag[i] == 8'h01 || cur_tag[i] == 8'h80))
                tags_legal = 1'b0;
        end
    end

    AST_PHYS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[PHYS_W-1:13] == cur_bank[cpu_addr[15:13]] &&
        mem_type == cur_tag[cpu_addr[15:13]]); // R2

    AST_SET8_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == 3'd1) |=>
        (cur_bank[$past(wr_win)] == $past(wr_banks[IDX_W-1:0]) &&
         cur_tag[$past(wr_win)] == 8'h00)); // R3

    AST_SET16_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == 3'd2) |=>
        (cur_bank[$past(pair_win)] == $past(IDX_W'({wr_banks[BANK_W-1:0], 1'b1})))); // R4

    AST_SET32_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == 3'd3) |=> (cur_bank[7] == $past(top_expect))); // R5

    AST_SET32Q_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == 3'd4) |=>
        ($stable(cur_bank[3:0]) && $stable(cur_tag[3:0]))); // R6

    AST_TAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == 3'd5) |=> (cur_bank[$past(wr_win)] == '0)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_op == 3'd0 || wr_op > 3'd5) |=>
        ($stable(cur_bank) && $stable(cur_tag))); // R8

    AST_TAG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        tags_legal); // R9

endmodule

bind prg_bank_xlat prg_bank_xlat_chk #(
    .ROM_BANKS (ROM_BANKS),
    .BANK_W    (BANK_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_op     (wr_op),
    .wr_win    (wr_win),
    .wr_banks  (wr_banks),
    .cpu_addr  (cpu_addr),
    .phys_addr (phys_addr),
    .mem_type  (mem_type),
    .cur_bank  (cur_bank),
    .cur_tag   (cur_tag)
);

// File: tb/test_prg_bank_xlat.sv
module test_prg_bank_xlat;

    localparam int N      = 16;
    localparam int BW     = 8;
    localparam int PHYS_W = $clog2(N) + 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_op = '0;
    logic [2:0]        wr_win = '0;
    logic [4*BW-1:0]   wr_banks = '0;
    logic [1:0]        wr_kind = '0;
    logic [15:0]       cpu_addr = '0;
    logic [PHYS_W-1:0] phys_addr;
    logic [7:0]        mem_type;

    int  mbank [8];
    int  mtag  [8];
    int  vectors = 0;
    int  fails = 0;
    int  seed = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    prg_bank_xlat #(.ROM_BANKS(N), .BANK_W(BW)) i_prg_bank_xlat (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_op     (wr_op),
        .wr_win    (wr_win),
        .wr_banks  (wr_banks),
        .wr_kind   (wr_kind),
        .cpu_addr  (cpu_addr),
        .phys_addr (phys_addr),
        .mem_type  (mem_type)
    );

    function automatic int kind_code(input int k);
        case (k)
            0:       return 8'h00;
            1:       return 8'hFF;
            2:       return 8'h01;
            default: return 8'h80;
        endcase
    endfunction

    task automatic check_one(input string req, input int w, input int ofs);
        int exp_phys;
        cpu_addr = 16'((w << 13) | ofs);
        #1;
        exp_phys = mbank[w] * 32'h2000 + ofs;
        vectors++;
        if (int'(phys_addr) != exp_phys || int'(mem_type) != mtag[w]) begin
            fails++;
            $display("FAIL %s win %0d addr %h: phys %h exp %h, type %h exp %h",
                     req, w, cpu_addr, phys_addr, exp_phys, mem_type, mtag[w]);
        end
    endtask

    task automatic check_all(input string req);
        for (int w = 0; w < 8; w++) begin
            seed = (seed * 7 + 613) & 16'h1FFF;
            check_one(req, w, seed);
            check_one(req, w, 13'h1FFF);
        end
    endtask

    task automatic do_write(input int op, input int win, input int b0, input int b1,
                            input int b2, input int b3, input int kind, input bit en);
        @(negedge clk);
        wr_en    = en;
        wr_op    = 3'(op);
        wr_win   = 3'(win);
        wr_banks = {8'(b3), 8'(b2), 8'(b1), 8'(b0)};
        wr_kind  = 2'(kind);
        @(negedge clk);
        wr_en = 1'b0;
        if (en) begin
            case (op)
                1: begin mbank[win] = b0 % N; mtag[win] = 8'h00; end
                2: begin
                    mbank[win] = (2 * b0) % N;           mtag[win] = 8'h00;
                    mbank[(win + 1) % 8] = (2 * b0 + 1) % N; mtag[(win + 1) % 8] = 8'h00;
                end
                3: for (int k = 0; k < 4; k++) begin
                    mbank[4 + k] = (4 * b0 + k) % N; mtag[4 + k] = 8'h00;
                end
                4: begin
                    mbank[4] = b0 % N; mbank[5] = b1 % N;
                    mbank[6] = b2 % N; mbank[7] = b3 % N;
                    for (int k = 4; k < 8; k++) mtag[k] = 8'h00;
                end
                5: begin mbank[win] = 0; mtag[win] = kind_code(kind); end
                default: ;
            endcase
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): run not finished, expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < 8; w++) begin
            mbank[w] = (w >= 4) ? (w - 4) % N : 0;
            mtag[w]  = (w >= 4) ? 8'h00 : 8'hFF;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");
        check_all("R2");

        for (int w = 0; w < 8; w++)
            for (int b = 0; b < 2 * N; b++) begin
                do_write(1, w, b * 3 + w, 0, 0, 0, 0, 1'b1);
                check_all("R3");
            end

        for (int w = 0; w < 8; w++)
            for (int b = 0; b < N; b++) begin
                do_write(2, w, b * 5 + 1, 0, 0, 0, 0, 1'b1);
                check_all("R4");
            end

        for (int w = 0; w < 8; w++)
            for (int k = 0; k < 4; k++) begin
                do_write(5, w, 0, 0, 0, 0, k, 1'b1);
                check_all("R7");
            end

        for (int b = 0; b < 2 * N; b++) begin
            do_write(3, b % 8, b * 9, 0, 0, 0, 0, 1'b1);
            check_all("R5");
        end

        do_write(5, 0, 0, 0, 0, 0, 3, 1'b1);
        do_write(5, 2, 0, 0, 0, 0, 2, 1'b1);
        for (int b = 0; b < 2 * N; b++) begin
            do_write(4, b % 8, b, b + 5, b * 3 + 9, 255 - b, 0, 1'b1);
            check_all("R6");
        end

        for (int op = 0; op < 8; op++) begin
            do_write(op, op, 7, 8, 9, 10, 1, 1'b0);
            check_all("R8");
        end
        do_write(0, 3, 11, 12, 13, 14, 1, 1'b1);
        check_all("R8");
        do_write(6, 1, 11, 12, 13, 14, 2, 1'b1);
        check_all("R8");
        do_write(7, 5, 11, 12, 13, 14, 3, 1'b1);
        check_all("R8");
        check_all("R9");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule